// File: doc/BRIEF.md
# Restartable Iterative Unsigned Multiplier

This block multiplies two unsigned operands over several clock cycles with one adder, retiring one bit of the second operand per enabled cycle. A one-cycle `in_valid` strobe captures both operands into internal registers and starts a new product. Any product still being formed at that moment is dropped. Once the last bit has been consumed, the full double-width product is written to a result register and `done` is raised.

A clock enable `ce` gates every register in the block. While it is low, the iteration pauses in place and the outputs hold their values. A surrounding controller can therefore stall the unit for any number of cycles, or restart it at any time, without resetting it.

Top module: `seqmul_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `done` is low and `prod` is zero.
- R2: An accepted request yields `prod` equal to the unsigned product `op_a * op_b` of the operands captured with it, zero-extended to 2*WIDTH bits.
- R3: A request is accepted at a rising edge where `ce` and `in_valid` are both high. `done` rises after exactly WIDTH further rising edges with `ce` high, counted after the accepting edge.
- R4: At an edge with `ce` low, nothing changes: no state is updated, `in_valid` is ignored, and `done` and `prod` keep their values.
- R5: A newly accepted request abandons any computation in progress. `done` is low in the cycle after it is accepted, and the next result belongs to the newest request.
- R6: Once high, `done` stays high and `prod` stays stable until the next accepted request or reset.
- R7: `prod` changes only at the edge where `done` rises. During a computation it keeps the previous result.
- R8: A request accepted at the same edge at which a computation would finish takes priority. `done` stays low and the older result is not written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable; low freezes all state |
| in_valid | input | 1 | Start strobe; captures operands when `ce` is high |
| op_a | input | WIDTH | Multiplicand, unsigned |
| op_b | input | WIDTH | Multiplier, unsigned |
| prod | output | 2*WIDTH | Registered product |
| done | output | 1 | High while `prod` holds the newest finished product |

## Verification
The properties assume that `rst` is synchronous and is held for at least one edge at start-up. They also assume that `ce` and `in_valid` carry known values at every sampled edge. Only in that case does "unchanged when disabled" hold. The stimulus drives every input on the falling edge from one task, so the values are always defined and settled before the rising edge. It mixes random `ce` gaps, random restarts, restarts timed to the finishing edge, and strobes issued while `ce` is low.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/seqmul_ctrl.sv
module seqmul_ctrl
    import seqmul_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic in_valid,
    output logic load,
    output logic step,
    output logic last
);
    localparam int CW = $clog2(WIDTH + 1);

    typedef struct packed {
        phase_e         phase;
        logic [CW-1:0]  left;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ce) begin
            if (in_valid) begin
                st_d.phase = PH_RUN;
                st_d.left  = CW'(WIDTH);
            end else if (st_q.phase == PH_RUN) begin
                st_d.left = st_q.left - CW'(1);
                if (st_q.left == CW'(1)) st_d.phase = PH_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign load = ce & in_valid;
    assign step = ce & ~in_valid & (st_q.phase == PH_RUN);
    assign last = step & (st_q.left == CW'(1));
endmodule

// File: rtl/seqmul_datapath.sv
module seqmul_datapath #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               step,
    input  logic               last,
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic [2*WIDTH-1:0] prod,
    output logic               done
);
    localparam int PW = 2 * WIDTH;

    typedef struct packed {
        logic [PW-1:0]    mcand;
        logic [WIDTH-1:0] mplier;
        logic [PW-1:0]    acc;
        logic [PW-1:0]    result;
        logic             fin;
    } dp_t;

    dp_t dp_d, dp_q;
    logic [PW-1:0] partial_sum;

    always_comb begin
        dp_d        = dp_q;
        partial_sum = dp_q.acc + (dp_q.mplier[0] ? dp_q.mcand : '0);
        if (load) begin
            dp_d.mcand  = {{WIDTH{1'b0}}, op_a};
            dp_d.mplier = op_b;
            dp_d.acc    = '0;
            dp_d.fin    = 1'b0;
        end else if (step) begin
            dp_d.mcand  = dp_q.mcand << 1;
            dp_d.mplier = dp_q.mplier >> 1;
            dp_d.acc    = partial_sum;
            if (last) begin
                dp_d.result = partial_sum;
                dp_d.fin    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) dp_q <= '0;
        else     dp_q <= dp_d;
    end

    assign prod = dp_q.result;
    assign done = dp_q.fin;
endmodule

// File: rtl/seqmul_top.sv
module seqmul_top #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ce,
    input  logic               in_valid,
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic [2*WIDTH-1:0] prod,
    output logic               done
);
    logic load, step, last;

    seqmul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk(clk), .rst(rst), .ce(ce), .in_valid(in_valid),
        .load(load), .step(step), .last(last)
    );

    seqmul_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk(clk), .rst(rst), .load(load), .step(step), .last(last),
        .op_a(op_a), .op_b(op_b), .prod(prod), .done(done)
    );
endmodule

// File: rtl/seqmul_checker.sv
module seqmul_checker #(
    parameter int WIDTH = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               ce,
    input logic               in_valid,
    input logic [2*WIDTH-1:0] prod,
    input logic               done
);
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!done && prod == '0));

    p_freeze_r4: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(done) && $stable(prod)));

    p_restart_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (ce && in_valid) |=> !done);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !(ce && in_valid)) |=> (done && $stable(prod)));

    p_prod_only_at_finish_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(prod) |-> $rose(done));
endmodule

bind seqmul_top seqmul_checker #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst(rst), .ce(ce), .in_valid(in_valid),
    .prod(prod), .done(done)
);

// File: tb/tb_seqmul_top.sv
module tb_seqmul_top;
    localparam int W  = 8;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce = 1'b0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic [PW-1:0] prod;
    logic          done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    seqmul_top #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .ce(ce), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .prod(prod), .done(done)
    );

    always #5 clk = ~clk;

    // behavioural reference: remaining enabled edges, latest operands, last result
    int            m_left = 0;
    logic          m_done = 1'b0;
    logic [PW-1:0] m_prod = '0;
    logic [PW-1:0] m_a = '0;
    logic [PW-1:0] m_b = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_left = 0; m_done = 1'b0; m_prod = '0;
        end else if (ce) begin
            if (in_valid) begin
                m_a = PW'(op_a); m_b = PW'(op_b);
                m_left = W; m_done = 1'b0;
            end else if (m_left > 0) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_done = 1'b1;
                    m_prod = m_a * m_b;
                end
            end
        end
    end

    task automatic check(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, sampled on the falling edge
    always @(negedge clk) begin
        if (!finished) begin
            check("R3 R5 R8 done", PW'(done), PW'(m_done));
            if (m_done) check("R2 R6 prod", prod, m_prod);
            else        check("R7 prod held", prod, m_prod);
        end
    end

    task automatic drive(input bit v, input bit c, input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        in_valid = v; ce = c; op_a = a; op_b = b;
    endtask

    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b);
        drive(1'b1, 1'b1, a, b);
        for (int i = 0; i < W + 3; i++) drive(1'b0, 1'b1, '0, '0);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #200000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=ended");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 done at reset", PW'(done), '0);
        check("R1 prod at reset", prod, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 done after release", PW'(done), '0);

        // R2: distinct operand patterns
        run(8'd13, 8'd11);
        check("R2 13*11", prod, 16'd143);
        run(8'hFF, 8'hFF);
        check("R2 max*max", prod, 16'hFE01);
        run(8'd0, 8'hA5);
        run(8'h80, 8'd1);

        // R3: exact latency counted in enabled edges
        drive(1'b1, 1'b1, 8'd7, 8'd9);
        for (int i = 0; i < W; i++) drive(1'b0, 1'b1, '0, '0);
        @(posedge clk); #1;
        check("R3 done after WIDTH edges", PW'(done), '1 >> (PW - 1));
        check("R3 product", prod, 16'd63);

        // R4: ce low freezes, strobe ignored while disabled
        drive(1'b1, 1'b1, 8'd21, 8'd3);
        drive(1'b0, 1'b1, '0, '0);
        for (int i = 0; i < 5; i++) drive(1'b1, 1'b0, 8'hEE, 8'hEE);
        for (int i = 0; i < W + 2; i++) drive(1'b0, 1'b1, '0, '0);
        check("R4 strobe ignored while disabled", prod, 16'd63);

        // R5: interrupt mid-computation
        drive(1'b1, 1'b1, 8'd200, 8'd200);
        for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, '0, '0);
        run(8'd5, 8'd6);
        check("R5 newest wins", prod, 16'd30);

        // R8: restart at the finishing edge
        drive(1'b1, 1'b1, 8'd99, 8'd99);
        for (int i = 0; i < W - 1; i++) drive(1'b0, 1'b1, '0, '0);
        drive(1'b1, 1'b1, 8'd2, 8'd3);
        drive(1'b0, 1'b1, '0, '0);
        check("R8 done low after collision", PW'(done), '0);
        check("R8 old result not written", prod, 16'd30);
        for (int i = 0; i < W + 2; i++) drive(1'b0, 1'b1, '0, '0);

        // R6: hold for a long idle stretch
        for (int i = 0; i < 10; i++) drive(1'b0, 1'b1, '0, '0);
        check("R6 held", prod, 16'd6);

        // back-to-back strobes every cycle
        for (int i = 0; i < 6; i++) drive(1'b1, 1'b1, W'(i + 3), W'(i + 7));
        for (int i = 0; i < W + 2; i++) drive(1'b0, 1'b1, '0, '0);

        // random stalls and restarts
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 99);
            drive(r < 6, ($urandom_range(0, 3) != 0), W'($urandom), W'($urandom));
        end
        for (int i = 0; i < 3 * W; i++) drive(1'b0, 1'b1, '0, '0);

        finish_run();
    end
endmodule